// File: doc/BRIEF.md
# Double-Buffered Wire Register Bank

This block holds a bank of 32-bit wire registers that a host-side bus shares with user logic. It has two groups of wires. The host writes host-to-user wires one at a time into shadow registers. A single commit pulse then copies every shadow to the user-facing outputs on the same clock edge, so user logic never sees a half-written set.

User-to-host wires work the other way round. A capture pulse freezes every user input into a snapshot register on one edge. The host then reads the snapshots back one address per access.

The host port is a plain write/read interface with an 8-bit address. Read data comes back one cycle after the request. When no read is being answered, the read-return bus is zero, so several such banks can share the bus through a bitwise OR.

Top module: `wire_bank_top`

## Requirements
- R1: Address map. Host-to-user wire n sits at address 0x00+n and user-to-host wire n at 0x20+n, for n from 0 to 31. Each wire is 32 bits. Wire n occupies bits [32n+31:32n] of `wire_out_o` and of `wire_in_i`.
- R2: A host write to 0x00–0x1F updates only that wire's shadow register. `wire_out_o` keeps its value until a commit. A read of the same address returns the shadow value.
- R3: A one-cycle `commit_i` copies all shadows to `wire_out_o` on a single edge, and `wire_out_o` changes only on that edge. A write issued in the same cycle as the commit is not part of that commit. A commit with no new writes leaves the outputs unchanged.
- R4: A one-cycle `capture_i` samples every wire of `wire_in_i` on the same edge. Each snapshot keeps its value until the next capture, whatever the inputs do in between.
- R5: A read of 0x20–0x3F returns that wire's snapshot. A read in the same cycle as a capture returns the snapshot from before that capture.
- R6: Read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled. Reads in consecutive cycles each return their own data.
- R7: `rdata_o` is zero in every cycle that does not follow a read request.
- R8: A write to 0x20–0x3F has no effect. An access to 0x40–0xFF has no effect, and a read there returns zero.
- R9: The active-low reset clears all shadows, all outputs, all snapshots and `rdata_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write request |
| rd_en_i | input | 1 | Host read request |
| addr_i | input | 8 | Wire address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read return, zero when idle |
| commit_i | input | 1 | Copy all shadows to the outputs |
| capture_i | input | 1 | Snapshot all user inputs |
| wire_in_i | input | 1024 | User-to-host wires, flattened |
| wire_out_o | output | 1024 | Host-to-user wires, flattened |

## Verification
The assertions check four things on every cycle:
- the outputs move only on the edge after a commit, and never because of a bare write;
- the read bus is zero whenever no read is being answered;
- a read of an unmapped address returns zero.

Only the bench scenarios can show the data itself. These include:
- that a commit carries the staged values and leaves out a write issued in the same cycle;
- that a snapshot survives later changes on the inputs and a capture that coincides with a read;
- that writes to the snapshot range or to unmapped addresses leave every readable value intact.

// File: rtl/wire_bank_pkg.sv
package wire_bank_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_STAGE = 2'd1,
    RGN_SNAP  = 2'd2
  } region_e;
endpackage

// File: rtl/wire_bank_dec.sv
module wire_bank_dec
  import wire_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int N_STAGE    = 32,
  parameter int N_SNAP     = 32,
  parameter int STAGE_BASE = 0,
  parameter int SNAP_BASE  = 32,
  localparam int SI_W = $clog2(N_STAGE),
  localparam int PI_W = $clog2(N_SNAP)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SI_W-1:0]   stage_idx_o,
  output logic [PI_W-1:0]   snap_idx_o
);
  localparam logic [ADDR_W-1:0] STAGE_BASE_A = ADDR_W'(STAGE_BASE);
  localparam logic [ADDR_W-1:0] SNAP_BASE_A  = ADDR_W'(SNAP_BASE);

  logic [ADDR_W-1:0] stage_off, snap_off;
  logic in_stage, in_snap;

  assign stage_off = addr_i - STAGE_BASE_A;
  assign snap_off  = addr_i - SNAP_BASE_A;
  assign in_stage  = (int'(addr_i) >= STAGE_BASE) && (int'(addr_i) < STAGE_BASE + N_STAGE);
  assign in_snap   = (int'(addr_i) >= SNAP_BASE) && (int'(addr_i) < SNAP_BASE + N_SNAP);

  always_comb begin
    if (in_stage)     region_o = RGN_STAGE;
    else if (in_snap) region_o = RGN_SNAP;
    else              region_o = RGN_NONE;
  end

  assign stage_idx_o = stage_off[SI_W-1:0];
  assign snap_idx_o  = snap_off[PI_W-1:0];
endmodule

// File: rtl/wire_stage_bank.sv
module wire_stage_bank #(
  parameter int DATA_W  = 32,
  parameter int N_STAGE = 32,
  localparam int SI_W = $clog2(N_STAGE),
  localparam int FLAT = DATA_W * N_STAGE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SI_W-1:0]   idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [FLAT-1:0]   shadow_o,
  output logic [FLAT-1:0]   wire_out_o
);
  for (genvar g = 0; g < N_STAGE; g++) begin : g_wire
    logic [DATA_W-1:0] shadow_q, out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                shadow_q <= '0;
      else if (wr_en_i && (idx_i == SI_W'(g)))    shadow_q <= wdata_i;
    end

    // commit takes pre-edge shadow: same-cycle write lands next commit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       out_q <= '0;
      else if (commit_i) out_q <= shadow_q;
    end

    assign shadow_o[g*DATA_W +: DATA_W]   = shadow_q;
    assign wire_out_o[g*DATA_W +: DATA_W] = out_q;
  end
endmodule

// File: rtl/wire_snap_bank.sv
module wire_snap_bank #(
  parameter int DATA_W = 32,
  parameter int N_SNAP = 32,
  localparam int FLAT = DATA_W * N_SNAP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [FLAT-1:0] wire_in_i,
  output logic [FLAT-1:0] snap_o
);
  for (genvar g = 0; g < N_SNAP; g++) begin : g_wire
    logic [DATA_W-1:0] snap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q <= '0;
      else if (capture_i) snap_q <= wire_in_i[g*DATA_W +: DATA_W];
    end

    assign snap_o[g*DATA_W +: DATA_W] = snap_q;
  end
endmodule

// File: rtl/wire_rd_ret.sv
module wire_rd_ret
  import wire_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_STAGE = 32,
  parameter int N_SNAP  = 32,
  localparam int SI_W = $clog2(N_STAGE),
  localparam int PI_W = $clog2(N_SNAP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  region_e                  region_i,
  input  logic [SI_W-1:0]          stage_idx_i,
  input  logic [PI_W-1:0]          snap_idx_i,
  input  logic [DATA_W*N_STAGE-1:0] shadow_i,
  input  logic [DATA_W*N_SNAP-1:0]  snap_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] sel_d, rdata_q;

  always_comb begin
    unique case (region_i)
      RGN_STAGE: sel_d = shadow_i[stage_idx_i*DATA_W +: DATA_W];
      RGN_SNAP:  sel_d = snap_i[snap_idx_i*DATA_W +: DATA_W];
      default:   sel_d = '0;
    endcase
  end

  // idle drives zero so banks can be OR-combined
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? sel_d : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/wire_bank_top.sv
module wire_bank_top
  import wire_bank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int N_STAGE    = 32,
  parameter int N_SNAP     = 32,
  parameter int STAGE_BASE = 0,
  parameter int SNAP_BASE  = 32,
  localparam int SI_W  = $clog2(N_STAGE),
  localparam int PI_W  = $clog2(N_SNAP),
  localparam int OUT_W = DATA_W * N_STAGE,
  localparam int IN_W  = DATA_W * N_SNAP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              commit_i,
  input  logic              capture_i,
  input  logic [IN_W-1:0]   wire_in_i,
  output logic [OUT_W-1:0]  wire_out_o
);
  region_e         region;
  logic [SI_W-1:0] stage_idx;
  logic [PI_W-1:0] snap_idx;
  logic [OUT_W-1:0] shadow;
  logic [IN_W-1:0]  snap;
  logic stage_wr;

  wire_bank_dec #(
    .ADDR_W(ADDR_W), .N_STAGE(N_STAGE), .N_SNAP(N_SNAP),
    .STAGE_BASE(STAGE_BASE), .SNAP_BASE(SNAP_BASE)
  ) u_dec (
    .addr_i(addr_i), .region_o(region),
    .stage_idx_o(stage_idx), .snap_idx_o(snap_idx)
  );

  assign stage_wr = wr_en_i && (region == RGN_STAGE);

  wire_stage_bank #(.DATA_W(DATA_W), .N_STAGE(N_STAGE)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(stage_wr), .idx_i(stage_idx),
    .wdata_i(wdata_i), .commit_i(commit_i),
    .shadow_o(shadow), .wire_out_o(wire_out_o)
  );

  wire_snap_bank #(.DATA_W(DATA_W), .N_SNAP(N_SNAP)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture_i),
    .wire_in_i(wire_in_i), .snap_o(snap)
  );

  wire_rd_ret #(.DATA_W(DATA_W), .N_STAGE(N_STAGE), .N_SNAP(N_SNAP)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .region_i(region),
    .stage_idx_i(stage_idx), .snap_idx_i(snap_idx),
    .shadow_i(shadow), .snap_i(snap), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/wire_bank_chk.sv
module wire_bank_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int N_STAGE    = 32,
  parameter int N_SNAP     = 32,
  parameter int STAGE_BASE = 0,
  parameter int SNAP_BASE  = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic                      rd_en_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      commit_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic [DATA_W*N_STAGE-1:0] wire_out_o
);
  logic unmapped;
  assign unmapped = !((int'(addr_i) >= STAGE_BASE && int'(addr_i) < STAGE_BASE + N_STAGE) ||
                      (int'(addr_i) >= SNAP_BASE && int'(addr_i) < SNAP_BASE + N_SNAP));

  // R3
  out_only_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(wire_out_o));

  // R2
  write_staged_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !commit_i) |=> $stable(wire_out_o));

  // R7
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> (rdata_o == '0));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && unmapped) |=> (rdata_o == '0));
endmodule

bind wire_bank_top wire_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_STAGE(N_STAGE), .N_SNAP(N_SNAP),
  .STAGE_BASE(STAGE_BASE), .SNAP_BASE(SNAP_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .commit_i(commit_i), .rdata_o(rdata_o), .wire_out_o(wire_out_o)
);

// File: tb/sim_wire_bank_top.sv
module sim_wire_bank_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NW = 32;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CM = 3'd2,
                         OP_CP = 3'd3, OP_OUT = 3'd4, OP_IN = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{OP_IN,  4'd4, 8'h00, 32'h1111_0000},
    '{OP_RD,  4'd9, 8'h20, 32'h0},           // R9 snapshot zero after reset
    '{OP_OUT, 4'd9, 8'd0,  32'h0},           // R9 outputs zero after reset
    '{OP_WR,  4'd1, 8'h00, 32'hDEAD_BEEF},
    '{OP_WR,  4'd1, 8'h1F, 32'h1234_5678},
    '{OP_OUT, 4'd2, 8'd0,  32'h0},           // R2 staged, not visible yet
    '{OP_RD,  4'd2, 8'h00, 32'hDEAD_BEEF},   // R2 shadow readback
    '{OP_CM,  4'd3, 8'h00, 32'h0},
    '{OP_OUT, 4'd3, 8'd0,  32'hDEAD_BEEF},   // R3
    '{OP_OUT, 4'd1, 8'd31, 32'h1234_5678},   // R1 top of range
    '{OP_CP,  4'd4, 8'h00, 32'h0},
    '{OP_IN,  4'd4, 8'h00, 32'h2222_0000},
    '{OP_RD,  4'd4, 8'h20, 32'h1111_0000},   // R4 held after input change
    '{OP_RD,  4'd5, 8'h3F, 32'h1111_001F},   // R5
    '{OP_CP,  4'd4, 8'h00, 32'h0},
    '{OP_RD,  4'd1, 8'h25, 32'h2222_0005},   // R1
    '{OP_WR,  4'd8, 8'h40, 32'hFFFF_FFFF},
    '{OP_RD,  4'd8, 8'h40, 32'h0},           // R8
    '{OP_RD,  4'd8, 8'hFF, 32'h0},           // R8
    '{OP_WR,  4'd8, 8'h21, 32'h0000_ABCD},
    '{OP_RD,  4'd8, 8'h21, 32'h2222_0001},   // R8 snapshot untouched
    '{OP_CM,  4'd3, 8'h00, 32'h0},
    '{OP_OUT, 4'd3, 8'd0,  32'hDEAD_BEEF}    // R3 commit without writes
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, commit = 1'b0, capture = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW*NW-1:0] wire_in = '0;
  logic [DW*NW-1:0] wire_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire_bank_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .commit_i(commit),
    .capture_i(capture), .wire_in_i(wire_in), .wire_out_o(wire_out)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic [31:0] gen);
    for (int i = 0; i < NW; i++) wire_in[i*DW +: DW] = gen ^ 32'(i);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic pulse_commit();
    commit = 1'b1; step(); commit = 1'b0;
  endtask

  task automatic pulse_capture();
    capture = 1'b1; step(); capture = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(9, rdata, 32'h0);                  // R9 read bus cleared in reset
    rst_ni = 1'b1;
    step();

    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        OP_WR:  do_wr(TBL[k].addr, TBL[k].data);
        OP_RD:  do_rd(int'(TBL[k].req), TBL[k].addr, TBL[k].data);
        OP_CM:  pulse_commit();
        OP_CP:  pulse_capture();
        OP_OUT: chk(int'(TBL[k].req), wire_out[int'(TBL[k].addr)*DW +: DW], TBL[k].data);
        default: set_in(TBL[k].data);
      endcase
    end

    // R3 write in commit cycle is left for the next commit
    wr_en = 1'b1; commit = 1'b1; addr = 8'h01; wdata = 32'h0BAD_CAFE;
    step();
    wr_en = 1'b0; commit = 1'b0;
    chk(3, wire_out[1*DW +: DW], 32'h0);
    pulse_commit();
    chk(3, wire_out[1*DW +: DW], 32'h0BAD_CAFE);

    // R5 read coinciding with capture returns the older snapshot
    set_in(32'h3333_0000);
    rd_en = 1'b1; capture = 1'b1; addr = 8'h22;
    step();
    rd_en = 1'b0; capture = 1'b0;
    chk(5, rdata, 32'h2222_0002);
    do_rd(5, 8'h22, 32'h3333_0002);

    // R6 back-to-back reads, R7 idle return
    rd_en = 1'b1; addr = 8'h00;
    step();
    chk(6, rdata, 32'hDEAD_BEEF);
    addr = 8'h3E;
    step();
    rd_en = 1'b0;
    chk(6, rdata, 32'h3333_001E);
    step();
    chk(7, rdata, 32'h0);

    // R9 reset mid-run
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    step();
    chk(9, wire_out[0 +: DW], 32'h0);
    chk(9, wire_out[31*DW +: DW], 32'h0);
    do_rd(9, 8'h00, 32'h0);
    do_rd(9, 8'h3E, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule